// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This block watches the status pins of a removable card socket and raises a single interrupt request when an enabled status event occurs. There are three kinds of event. A card-detect event fires when either detect line changes. A ready event fires when the ready/busy line rises. A battery-warning event fires when the two battery-voltage lines enter the state that means "replace the battery, data still retained". Every pin passes through a synchroniser before its edge or change is detected.

Software sees a 4-bit control register and a 4-bit status register. The control register holds one enable per event. The status register holds one sticky flag per event, and software clears a flag by writing 1 to it. A mode input selects memory-card or I/O-card operation. In I/O mode the ready and battery events are suppressed.

Two small state machines set the timing. The arming machine has two states. `ARM_WAIT` moves to `ARM_LIVE` after SYNC_STAGES+1 clocks from reset, and events are recognised only in `ARM_LIVE`. The battery machine tracks the decoded battery state. It moves every clock among `BAT_GOOD` (BVD1=1, BVD2=1), `BAT_WARN` (BVD1=1, BVD2=0) and `BAT_LOST` (BVD1=0), and can go from any state to any other. Only the transition into `BAT_WARN` from another state produces a battery event.

Top module: `card_status_irq`

## Requirements
- R1: After reset both registers read 0 and `irq` is 0.
- R2: A change in either direction on `cd_pin[0]` or `cd_pin[1]` sets status bit 3. The flag becomes visible on the third rising clock edge after the pin change and not before.
- R3: In memory mode (`mem_mode`=1), a 0-to-1 transition of `rdy_pin` sets status bit 2. A 1-to-0 transition sets nothing.
- R4: `bvd_pin[0]` is BVD1 and `bvd_pin[1]` is BVD2. Entering code 2'b01 from any other code sets status bit 1 in memory mode. Codes 2'b11, 2'b00 and 2'b10 set nothing. Staying in 2'b01 after the flag is cleared does not set the flag again.
- R5: In I/O mode (`mem_mode`=0), ready and battery events set no flag, and flags already in status bits 2 and 1 do not drive `irq`.
- R6: Writing the status register (`addr`=1) clears each flag whose `wdata` bit is 1 and leaves the others alone. If a flag is set and cleared in the same cycle, it stays set.
- R7: `irq` is the OR of status bits 3..1 ANDed with the matching control bits 3..1 (bit 3 card detect, bit 2 ready, bit 1 battery). A flag whose enable is 0 never asserts `irq`.
- R8: Pin levels present at reset, and changes during the first SYNC_STAGES+1 clocks after reset, set no flag.
- R9: Writing the control register (`addr`=0) stores bits 3..1. Bit 0 always reads 0 in both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cd_pin | input | 2 | Card-detect lines, asynchronous |
| rdy_pin | input | 1 | Ready/busy line, asynchronous |
| bvd_pin | input | 2 | Battery-voltage lines: [0]=BVD1, [1]=BVD2 |
| mem_mode | input | 1 | 1 = memory card, 0 = I/O card |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control, 1 = status |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
If the battery machine holds the wrong state, a flag appears or goes missing on the transition into 2'b01. With the flag enabled, the wrong value shows on `irq` three clocks after the pin change. A bad previous-sample register or a misplaced arming state shows up as a status flag read back one clock too early or too late. It can also show as a spurious flag right after reset. A wrong clear or mask term shows as soon as the next read or the same cycle's `irq`. The bench sweeps every pair of battery codes, both directions of every pin in both modes, and every enable.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int REG_W   = 4;
    localparam int BIT_CD  = 3;
    localparam int BIT_RDY = 2;
    localparam int BIT_BAT = 1;
    localparam logic [REG_W-1:0] RW_MASK = 4'b1110;

    typedef enum logic [1:0] {
        BAT_GOOD = 2'd0,
        BAT_WARN = 2'd1,
        BAT_LOST = 2'd2
    } bat_state_e;

    typedef enum logic {
        ARM_WAIT = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_e;

    // bvd[0] = BVD1, bvd[1] = BVD2
    function automatic bat_state_e bat_decode(input logic [1:0] bvd);
        if (!bvd[0])     return BAT_LOST;
        else if (bvd[1]) return BAT_GOOD;
        else             return BAT_WARN;
    endfunction
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/csi_bat_fsm.sv
module csi_bat_fsm
    import csi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bvd_s,
    input  logic       armed,
    input  logic       mem_mode,
    output bat_state_e state,
    output logic       warn_evt
);
    bat_state_e nxt;

    always_comb begin
        unique case (bat_decode(bvd_s))
            BAT_GOOD: nxt = BAT_GOOD;
            BAT_WARN: nxt = BAT_WARN;
            default:  nxt = BAT_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BAT_LOST;
        else        state <= nxt;
    end

    always_comb begin
        warn_evt = armed && mem_mode && (nxt == BAT_WARN) && (state != BAT_WARN);
    end
endmodule

// File: rtl/csi_regs.sv
module csi_regs
    import csi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] clr_vec;

    always_comb clr_vec = (wr_en && addr) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en && !addr) ctrl_q <= wdata & RW_MASK;
            stat_q <= ((stat_q & ~clr_vec) | set_vec) & RW_MASK;
        end
    end

    always_comb rdata = addr ? stat_q : ctrl_q;
endmodule

// File: rtl/card_status_irq.sv
module card_status_irq
    import csi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cd_pin,
    input  logic       rdy_pin,
    input  logic [1:0] bvd_pin,
    input  logic       mem_mode,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [3:0] wdata,
    output logic [3:0] rdata,
    output logic       irq
);
    localparam int WARM    = SYNC_STAGES + 1;
    localparam int CNT_W   = $clog2(WARM + 1);
    localparam int PIN_CNT = 5;

    logic [PIN_CNT-1:0] pins_s;
    logic [1:0]         cd_s, bvd_s, cd_prev;
    logic               rdy_s, rdy_prev;
    arm_state_e         arm_q, arm_d;
    logic [CNT_W-1:0]   cnt_q;
    logic               armed;
    bat_state_e         bat_state;
    logic               bat_evt, cd_evt, rdy_evt;
    logic [REG_W-1:0]   set_vec, ctrl_q, stat_q, live_mask;

    csi_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bvd_pin, rdy_pin, cd_pin}), .q(pins_s)
    );
    assign cd_s  = pins_s[1:0];
    assign rdy_s = pins_s[2];
    assign bvd_s = pins_s[4:3];

    // arming state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_WAIT;
            cnt_q <= '0;
        end else begin
            arm_q <= arm_d;
            if (arm_q == ARM_WAIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    // arming state machine: next state and outputs
    always_comb begin
        unique case (arm_q)
            ARM_WAIT: arm_d = (cnt_q == CNT_W'(WARM - 1)) ? ARM_LIVE : ARM_WAIT;
            ARM_LIVE: arm_d = ARM_LIVE;
            default:  arm_d = ARM_WAIT;
        endcase
        armed = (arm_q == ARM_LIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_prev  <= '0;
            rdy_prev <= 1'b0;
        end else begin
            cd_prev  <= cd_s;
            rdy_prev <= rdy_s;
        end
    end

    csi_bat_fsm u_bat (
        .clk(clk), .rst_n(rst_n), .bvd_s(bvd_s), .armed(armed),
        .mem_mode(mem_mode), .state(bat_state), .warn_evt(bat_evt)
    );

    always_comb begin
        cd_evt  = armed && (cd_s != cd_prev);
        rdy_evt = armed && mem_mode && rdy_s && !rdy_prev;
        set_vec = '0;
        set_vec[BIT_CD]  = cd_evt;
        set_vec[BIT_RDY] = rdy_evt;
        set_vec[BIT_BAT] = bat_evt;
    end

    csi_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .set_vec(set_vec), .ctrl_q(ctrl_q), .stat_q(stat_q), .rdata(rdata)
    );

    always_comb begin
        live_mask = '0;
        live_mask[BIT_CD]  = 1'b1;
        live_mask[BIT_RDY] = mem_mode;
        live_mask[BIT_BAT] = mem_mode;
        irq = |(stat_q & ctrl_q & live_mask);
    end
endmodule

// File: rtl/card_status_irq_chk.sv
module card_status_irq_chk
    import csi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mem_mode,
    input logic       wr_en,
    input logic       addr,
    input logic [3:0] wdata,
    input logic       irq,
    input logic [3:0] ctrl_q,
    input logic [3:0] stat_q,
    input bat_state_e bat_state,
    input logic       armed
);
    logic [3:0] clr_seen;
    always_comb clr_seen = (wr_en && addr) ? wdata : 4'b0;

    // R7
    no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3:1] == 3'b000) |-> !irq);

    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(clr_seen)) & ~stat_q) == 4'b0));

    // R3
    rdy_flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> $past(mem_mode));

    // R4
    bat_flag_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[1]) |-> (bat_state == BAT_WARN));

    // R5
    io_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_mode |-> (irq == (stat_q[3] && ctrl_q[3])));

    // R8
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (stat_q == 4'b0));
endmodule

bind card_status_irq card_status_irq_chk u_chk (.*);

// File: tb/card_status_irq_test.sv
`timescale 1ns/1ps
module card_status_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cd = 2'b00;
    logic       rdy = 1'b0;
    logic [1:0] bvd = 2'b00;
    logic       mem_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [3:0] wdata = 4'b0;
    logic [3:0] rdata;
    logic       irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    card_status_irq uut (
        .clk(clk), .rst_n(rst_n), .cd_pin(cd), .rdy_pin(rdy), .bvd_pin(bvd),
        .mem_mode(mem_mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0; wdata = 4'b0;
    endtask

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic a, input logic [3:0] exp);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        #1;
        chk(tag, {3'b0, irq}, {3'b0, exp});
    endtask

    initial begin
        // R8: pins active while in reset
        cd = 2'b11; rdy = 1'b1; bvd = 2'b01;
        tick(3);
        rst_n = 1'b1;
        // R1
        rd_chk("R1 ctrl after reset", 1'b0, 4'b0000);
        rd_chk("R1 status after reset", 1'b1, 4'b0000);
        irq_chk("R1 irq after reset", 1'b0);
        tick(6);
        rd_chk("R8 no flag from reset levels", 1'b1, 4'b0000);

        // R9
        wr(1'b0, 4'b1111);
        rd_chk("R9 ctrl bit0 reads 0", 1'b0, 4'b1110);
        wr(1'b0, 4'b0101);
        rd_chk("R9 ctrl store", 1'b0, 4'b0100);
        wr(1'b0, 4'b0000);

        cd = 2'b00; rdy = 1'b0; bvd = 2'b00;
        tick(4);
        wr(1'b1, 4'b1110);
        rd_chk("R6 clear all", 1'b1, 4'b0000);

        // R2 sweep: each line, both directions
        wr(1'b0, 4'b1000);
        for (int k = 0; k < 4; k++) begin
            cd[k % 2] = ~cd[k % 2];
            tick(2);
            rd_chk("R2 not before third edge", 1'b1, 4'b0000);
            tick(1);
            rd_chk("R2 cd flag", 1'b1, 4'b1000);
            irq_chk("R2 irq", 1'b1);
            wr(1'b1, 4'b1000);
            rd_chk("R6 cd cleared", 1'b1, 4'b0000);
            irq_chk("R6 irq drops", 1'b0);
        end

        // R7: flag with enable 0
        wr(1'b0, 4'b0000);
        cd[0] = ~cd[0];
        tick(3);
        rd_chk("R7 flag set while disabled", 1'b1, 4'b1000);
        irq_chk("R7 disabled no irq", 1'b0);
        wr(1'b0, 4'b1000);
        irq_chk("R7 enable raises irq", 1'b1);

        // R6: write 0 keeps flag; set and clear in the same cycle
        wr(1'b1, 4'b0110);
        rd_chk("R6 other bits keep flag", 1'b1, 4'b1000);
        cd[1] = ~cd[1];
        tick(2);
        wr(1'b1, 4'b1000);
        rd_chk("R6 set wins over clear", 1'b1, 4'b1000);
        wr(1'b1, 4'b1000);
        rd_chk("R6 clear after", 1'b1, 4'b0000);

        // R3: ready both directions, memory mode
        wr(1'b0, 4'b0100);
        for (int k = 0; k < 4; k++) begin
            logic rise;
            rise = ~rdy;
            rdy = ~rdy;
            tick(3);
            rd_chk("R3 rdy flag", 1'b1, {1'b0, rise, 2'b00});
            irq_chk("R3 rdy irq", rise);
            wr(1'b1, 4'b0100);
        end

        // R4: all code pairs, memory mode
        wr(1'b0, 4'b0010);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic exp;
                bvd = a[1:0];
                tick(4);
                wr(1'b1, 4'b1110);
                bvd = b[1:0];
                tick(4);
                exp = (b == 1) && (a != 1);
                rd_chk("R4 battery pair", 1'b1, {2'b00, exp, 1'b0});
                irq_chk("R4 battery irq", exp);
                wr(1'b1, 4'b0010);
            end
        end
        bvd = 2'b11; tick(4);
        bvd = 2'b01; tick(4);
        wr(1'b1, 4'b0010);
        tick(6);
        rd_chk("R4 no retrigger while in warning", 1'b1, 4'b0000);

        // R5: I/O mode
        bvd = 2'b11; rdy = 1'b0; tick(4);
        wr(1'b1, 4'b1110);
        wr(1'b0, 4'b1110);
        mem_mode = 1'b0;
        rdy = 1'b1; bvd = 2'b01;
        tick(4);
        rd_chk("R5 io mode no rdy/bat flag", 1'b1, 4'b0000);
        irq_chk("R5 io mode irq low", 1'b0);
        rdy = 1'b0; bvd = 2'b11; tick(4);
        mem_mode = 1'b1;
        rdy = 1'b1; tick(3);
        rd_chk("R3 rdy flag before mode switch", 1'b1, 4'b0100);
        mem_mode = 1'b0;
        irq_chk("R5 io mode masks flag", 1'b0);
        rd_chk("R5 flag kept in io mode", 1'b1, 4'b0100);
        mem_mode = 1'b1;
        irq_chk("R5 memory mode unmasks", 1'b1);
        wr(1'b1, 4'b0100);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule